// File: doc/BRIEF.md
# Hybrid Product-Term Logic Block

This block is one logic cell of a small programmable fabric. It evaluates a set of product terms over a bus of routed input signals and forms one sum per output macrocell. Each macrocell owns a short list of dedicated terms that are ORed into its sum. A separately held pool of terms can be routed through a programmable OR array into any mix of macrocells, and a single pool term may reach several outputs at once. Each sum then passes through the macrocell, either directly or through a register. That register has a selectable clock and polarity and an asynchronous set and clear driven by configurable control terms.

The configuration lives in one long register that is filled bit by bit over a serial strobe/data/commit interface clocked by the fabric clock. While bits are moving, and until the commit strobe arrives, no output is enabled. A global high-impedance input removes every output enable at once, whatever the configuration says.

Default sizing: 8 inputs, 16 macrocells, 5 dedicated terms per macrocell, 32 pool terms, 4 macrocell clocks and 4 control terms. That gives a configuration image of 2596 bits.

Top module: `hyb_logic_block`

## Requirements
- R1: After `rst_n` is released, no configuration is committed, `mc_oe` is all zero and `mc_out` is all zero.
- R2: Each clock with `cfg_shift` high shifts `cfg_sdi` into bit 0 of the image and moves every bit one place up, so the first bit sent ends at bit 2595. A shift clears the committed state, which blanks every enable from the following cycle on. A `cfg_load` cycle with no shift commits the image, and the enables apply from the next cycle.
- R3: Product term t takes its mask from image bits [16t+15:16t]. Mask bit i selects `in_bus[i]` and bit 8+i selects its complement. The term is the AND of the selected literals. A term whose mask is all zero is 0.
- R4: Terms 5m to 5m+4 are the dedicated terms of macrocell m, and all five are ORed into its sum.
- R5: Terms 80 to 111 form the pool, with p = t-80. Image bit 1792+16p+m routes pool term p into the sum of macrocell m. One pool term may be routed to many macrocells.
- R6: A single macrocell sum can include all 5 of its dedicated terms and all 32 pool terms, 37 in all.
- R7: Macrocell m has a 14-bit field at image bit 2372+14m. Field bits [1:0] pick the register clock from `gclk`. Bit [2] set makes the register capture on the falling edge of that clock instead of the rising edge. Edges on the other clocks are ignored.
- R8: When field bit [3] is 1, `mc_out[m]` is the sum itself. When it is 0, `mc_out[m]` is the register output.
- R9: Control term c uses image bits [2304+17c+15 : 2304+17c] as a literal mask and bit 2304+17c+16 as its mode (1 = OR of the selected literals, 0 = AND, with an empty AND giving 0). Field bits [5:4] of a macrocell set its enable: 0 off, 1 on, 2 the control term selected by bits [7:6], 3 that control term inverted.
- R10: Field bit [8] enables an asynchronous set from the control term at bits [10:9]. Bit [11] enables an asynchronous clear from the control term at bits [13:12]. When both are active, the clear wins. When the clear releases while the set is still active, the register goes to 1.
- R11: While `gts` is high, every `mc_oe` bit is 0. `mc_out` is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock for the configuration register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sdi | input | 1 | Serial configuration data |
| cfg_shift | input | 1 | Shift strobe, sampled on `clk` |
| cfg_load | input | 1 | Commit strobe, sampled on `clk` |
| gclk | input | 4 | Global macrocell clocks |
| gts | input | 1 | Global output-disable |
| in_bus | input | 8 | Routed input signals |
| mc_out | output | 16 | Macrocell values |
| mc_oe | output | 16 | Macrocell output enables |

## Verification
Two functions can be active in the same instant: a macrocell's asynchronous clear and its asynchronous set, because both come from control terms that look at the same input bus. The bench raises the set input alone, then the clear input alone, then both together. It then drops only the clear and reads the macrocell value at each step. A correct block shows 1, then 0, 0 while both are active, and 1 again once the clear releases under a held set. A second pairing is a reload of the image while enables are live: the bench checks that the enables are blank in the middle of the shift and return once the image is committed.

// File: rtl/hyb_pkg.sv
package hyb_pkg;

    localparam int HYB_N_IN      = 8;
    localparam int HYB_N_MC      = 16;
    localparam int HYB_N_DED     = 5;
    localparam int HYB_N_POOL    = 32;
    localparam int HYB_N_CLK     = 4;
    localparam int HYB_N_CT      = 4;
    localparam int HYB_CLK_SEL_W = $clog2(HYB_N_CLK);
    localparam int HYB_CT_SEL_W  = $clog2(HYB_N_CT);

    typedef enum logic [1:0] {
        OE_OFF  = 2'd0,
        OE_ON   = 2'd1,
        OE_CT   = 2'd2,
        OE_CT_N = 2'd3
    } oe_mode_e;

    // Per-macrocell field, listed from MSB to LSB
    typedef struct packed {
        logic [HYB_CT_SEL_W-1:0]  clr_ct;
        logic                     clr_en;
        logic [HYB_CT_SEL_W-1:0]  set_ct;
        logic                     set_en;
        logic [HYB_CT_SEL_W-1:0]  oe_ct;
        oe_mode_e                 oe_mode;
        logic                     bypass;
        logic                     clk_inv;
        logic [HYB_CLK_SEL_W-1:0] clk_sel;
    } mc_cfg_t;

    localparam int HYB_MC_W = $bits(mc_cfg_t);

endpackage

// File: rtl/hyb_pterm_array.sv
module hyb_pterm_array #(
    parameter int N_IN   = 8,
    parameter int N_TERM = 112
) (
    input  logic [N_IN-1:0]            in_bus,
    input  logic [N_TERM*2*N_IN-1:0]   mask_flat,
    output logic [N_TERM-1:0]          pt
);
    localparam int LIT = 2 * N_IN;

    logic [LIT-1:0] lit;
    assign lit = {~in_bus, in_bus};

    generate
        for (genvar t = 0; t < N_TERM; t++) begin : g_term
            logic [LIT-1:0] msk;
            assign msk   = mask_flat[t*LIT +: LIT];
            // empty mask evaluates to 0 so idle terms never pollute a sum
            assign pt[t] = (|msk) & (&(lit | ~msk));
        end
    endgenerate
endmodule

// File: rtl/hyb_ctl_terms.sv
module hyb_ctl_terms #(
    parameter int N_IN = 8,
    parameter int N_CT = 4
) (
    input  logic [N_IN-1:0]              in_bus,
    input  logic [N_CT*(2*N_IN+1)-1:0]   ct_cfg,
    output logic [N_CT-1:0]              ct
);
    localparam int LIT  = 2 * N_IN;
    localparam int CT_W = LIT + 1;

    logic [LIT-1:0] lit;
    assign lit = {~in_bus, in_bus};

    generate
        for (genvar c = 0; c < N_CT; c++) begin : g_ct
            logic [LIT-1:0] msk;
            logic           sum_mode;
            logic           as_sum;
            logic           as_prod;
            assign msk      = ct_cfg[c*CT_W +: LIT];
            assign sum_mode = ct_cfg[c*CT_W + LIT];
            assign as_sum   = |(lit & msk);
            assign as_prod  = (|msk) & (&(lit | ~msk));
            assign ct[c]    = sum_mode ? as_sum : as_prod;
        end
    endgenerate
endmodule

// File: rtl/hyb_or_array.sv
module hyb_or_array #(
    parameter int N_MC   = 16,
    parameter int N_DED  = 5,
    parameter int N_POOL = 32
) (
    input  logic [N_MC*N_DED-1:0]   ded_pt,
    input  logic [N_POOL-1:0]       pool_pt,
    input  logic [N_POOL*N_MC-1:0]  or_map,
    output logic [N_MC-1:0]         sum
);
    always_comb begin
        for (int m = 0; m < N_MC; m++) begin
            logic acc;
            acc = |ded_pt[m*N_DED +: N_DED];
            for (int p = 0; p < N_POOL; p++) begin
                acc = acc | (pool_pt[p] & or_map[p*N_MC + m]);
            end
            sum[m] = acc;
        end
    end
endmodule

// File: rtl/hyb_macrocell.sv
module hyb_macrocell
    import hyb_pkg::*;
#(
    parameter int N_CLK = 4,
    parameter int N_CT  = 4
) (
    input  logic             rst_n,
    input  logic [N_CLK-1:0] gclk,
    input  mc_cfg_t          cfg,
    input  logic             sum,
    input  logic [N_CT-1:0]  ct,
    output logic             q_out,
    output logic             oe_raw,
    output logic             reg_q,
    output logic             set_act,
    output logic             clr_act
);
    logic mclk;
    logic set_eff;
    logic q_d;
    logic q_q;

    assign mclk    = gclk[cfg.clk_sel] ^ cfg.clk_inv;
    assign set_act = cfg.set_en & ct[cfg.set_ct];
    assign clr_act = (cfg.clr_en & ct[cfg.clr_ct]) | ~rst_n;
    // set is masked by clear, so releasing clear under a held set is an edge
    assign set_eff = set_act & ~clr_act;

    always_comb begin
        q_d = sum;
    end

    always_ff @(posedge mclk or posedge clr_act or posedge set_eff) begin
        if (clr_act) begin
            q_q <= 1'b0;
        end else if (set_eff) begin
            q_q <= 1'b1;
        end else begin
            q_q <= q_d;
        end
    end

    assign reg_q = q_q;
    assign q_out = cfg.bypass ? sum : q_q;

    always_comb begin
        unique case (cfg.oe_mode)
            OE_OFF:  oe_raw = 1'b0;
            OE_ON:   oe_raw = 1'b1;
            OE_CT:   oe_raw = ct[cfg.oe_ct];
            OE_CT_N: oe_raw = ~ct[cfg.oe_ct];
            default: oe_raw = 1'b0;
        endcase
    end
endmodule

// File: rtl/hyb_logic_block.sv
module hyb_logic_block
    import hyb_pkg::*;
#(
    parameter int N_IN   = HYB_N_IN,
    parameter int N_MC   = HYB_N_MC,
    parameter int N_DED  = HYB_N_DED,
    parameter int N_POOL = HYB_N_POOL,
    parameter int N_CLK  = HYB_N_CLK,
    parameter int N_CT   = HYB_N_CT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_sdi,
    input  logic             cfg_shift,
    input  logic             cfg_load,
    input  logic [N_CLK-1:0] gclk,
    input  logic             gts,
    input  logic [N_IN-1:0]  in_bus,
    output logic [N_MC-1:0]  mc_out,
    output logic [N_MC-1:0]  mc_oe
);
    localparam int LIT     = 2 * N_IN;
    localparam int N_DPT   = N_MC * N_DED;
    localparam int N_PT    = N_DPT + N_POOL;
    localparam int PT_W    = N_PT * LIT;
    localparam int OR_BASE = PT_W;
    localparam int OR_W    = N_POOL * N_MC;
    localparam int CT_BASE = OR_BASE + OR_W;
    localparam int CT_W    = N_CT * (LIT + 1);
    localparam int MC_BASE = CT_BASE + CT_W;
    localparam int CFG_W   = MC_BASE + N_MC * HYB_MC_W;

    typedef struct packed {
        logic [CFG_W-1:0] bits;
        logic             valid;
    } cfg_state_t;

    cfg_state_t st_d;
    cfg_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_shift) begin
            st_d.bits  = {st_q.bits[CFG_W-2:0], cfg_sdi};
            st_d.valid = 1'b0;
        end else if (cfg_load) begin
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic cfg_valid;
    assign cfg_valid = st_q.valid;

    logic [N_PT-1:0] pt;
    logic [N_CT-1:0] ct;
    logic [N_MC-1:0] sum;
    logic [N_MC-1:0] oe_raw;
    logic [N_MC-1:0] reg_q;
    logic [N_MC-1:0] set_act;
    logic [N_MC-1:0] clr_act;

    hyb_pterm_array #(.N_IN(N_IN), .N_TERM(N_PT)) u_pt (
        .in_bus    (in_bus),
        .mask_flat (st_q.bits[PT_W-1:0]),
        .pt        (pt)
    );

    hyb_ctl_terms #(.N_IN(N_IN), .N_CT(N_CT)) u_ct (
        .in_bus (in_bus),
        .ct_cfg (st_q.bits[CT_BASE +: CT_W]),
        .ct     (ct)
    );

    hyb_or_array #(.N_MC(N_MC), .N_DED(N_DED), .N_POOL(N_POOL)) u_or (
        .ded_pt  (pt[N_DPT-1:0]),
        .pool_pt (pt[N_PT-1:N_DPT]),
        .or_map  (st_q.bits[OR_BASE +: OR_W]),
        .sum     (sum)
    );

    generate
        for (genvar m = 0; m < N_MC; m++) begin : g_mc
            mc_cfg_t mcfg;
            assign mcfg = mc_cfg_t'(st_q.bits[MC_BASE + m*HYB_MC_W +: HYB_MC_W]);

            hyb_macrocell #(.N_CLK(N_CLK), .N_CT(N_CT)) u_mc (
                .rst_n   (rst_n),
                .gclk    (gclk),
                .cfg     (mcfg),
                .sum     (sum[m]),
                .ct      (ct),
                .q_out   (mc_out[m]),
                .oe_raw  (oe_raw[m]),
                .reg_q   (reg_q[m]),
                .set_act (set_act[m]),
                .clr_act (clr_act[m])
            );
        end
    endgenerate

    assign mc_oe = oe_raw & {N_MC{cfg_valid & ~gts}};
endmodule

// File: rtl/hyb_logic_block_chk.sv
module hyb_logic_block_chk #(
    parameter int N_MC = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_shift,
    input logic            cfg_load,
    input logic            gts,
    input logic            cfg_valid,
    input logic [N_MC-1:0] mc_oe,
    input logic [N_MC-1:0] reg_q,
    input logic [N_MC-1:0] set_act,
    input logic [N_MC-1:0] clr_act
);
    a_r1_uncommitted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |-> (mc_oe == '0));

    a_r2_shift_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shift |=> (mc_oe == '0));

    a_r2_load_commits: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && !cfg_shift) |=> cfg_valid);

    a_r11_gts_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        gts |-> (mc_oe == '0));

    a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_act & $past(clr_act) & reg_q) == '0));

    a_r10_set_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_act & ~clr_act & $past(set_act & ~clr_act) & ~reg_q) == '0));
endmodule

bind hyb_logic_block hyb_logic_block_chk #(.N_MC(N_MC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_shift (cfg_shift),
    .cfg_load  (cfg_load),
    .gts       (gts),
    .cfg_valid (cfg_valid),
    .mc_oe     (mc_oe),
    .reg_q     (reg_q),
    .set_act   (set_act),
    .clr_act   (clr_act)
);

// File: tb/sim_hyb_logic_block.sv
module sim_hyb_logic_block;
    localparam int LIT = 16;
    localparam int ORB = 1792;
    localparam int CTB = 2304;
    localparam int CTW = 17;
    localparam int MCB = 2372;
    localparam int MCW = 14;
    localparam int CW  = 2596;
    localparam logic [15:0] COMB_MASK = 16'h031F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_sdi = 1'b0;
    logic        cfg_shift = 1'b0;
    logic        cfg_load = 1'b0;
    logic [3:0]  gclk = 4'h0;
    logic        gts = 1'b0;
    logic [7:0]  in_bus = 8'h00;
    logic [15:0] mc_out;
    logic [15:0] mc_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hyb_logic_block u0 (
        .clk (clk), .rst_n (rst_n), .cfg_sdi (cfg_sdi), .cfg_shift (cfg_shift),
        .cfg_load (cfg_load), .gclk (gclk), .gts (gts), .in_bus (in_bus),
        .mc_out (mc_out), .mc_oe (mc_oe)
    );

    typedef struct {
        string       tag;
        logic [15:0] eo;
        logic [15:0] eoe;
        logic [15:0] mask;
    } item_t;
    item_t sbq[$];

    logic [CW-1:0] img = '0;

    // ---------------- reference model built from the requirements -------
    function automatic logic pt_val(logic [15:0] msk, logic [7:0] x);
        logic [15:0] lit;
        lit = {~x, x};
        return (|msk) && ((lit | ~msk) == 16'hFFFF);
    endfunction

    function automatic logic ct_val(int c, logic [7:0] x);
        logic [15:0] msk;
        msk = img[CTB + c*CTW +: 16];
        if (img[CTB + c*CTW + 16]) return |({~x, x} & msk);
        return pt_val(msk, x);
    endfunction

    function automatic logic [15:0] exp_sum(logic [7:0] x);
        logic [15:0] r;
        r = '0;
        for (int m = 0; m < 16; m++) begin
            for (int k = 0; k < 5; k++) r[m] = r[m] | pt_val(img[(m*5+k)*LIT +: LIT], x);
            for (int p = 0; p < 32; p++)
                if (img[ORB + p*16 + m]) r[m] = r[m] | pt_val(img[(80+p)*LIT +: LIT], x);
        end
        return r;
    endfunction

    function automatic logic [15:0] exp_oe(logic [7:0] x, logic g);
        logic [15:0] r;
        r = '0;
        for (int m = 0; m < 16; m++) begin
            logic [13:0] f;
            f = img[MCB + m*MCW +: MCW];
            case (f[5:4])
                2'd1:    r[m] = 1'b1;
                2'd2:    r[m] = ct_val(int'(f[7:6]), x);
                2'd3:    r[m] = ~ct_val(int'(f[7:6]), x);
                default: r[m] = 1'b0;
            endcase
        end
        return g ? 16'h0000 : r;
    endfunction

    function automatic logic [15:0] tru(int i);  return 16'(1) << i;       endfunction
    function automatic logic [15:0] cmp(int i);  return 16'(1) << (8 + i); endfunction

    function automatic logic [13:0] mcf(logic [1:0] cs, logic inv, logic byp, logic [1:0] oem,
                                        logic [1:0] oct, logic se, logic [1:0] sct,
                                        logic ce, logic [1:0] cct);
        return {cct, ce, sct, se, oct, oem, byp, inv, cs};
    endfunction

    // ---------------- driver side -----------------------------------------
    task automatic expect_state(string tag, logic [15:0] eo, logic [15:0] eoe, logic [15:0] mask);
        item_t it;
        it.tag = tag; it.eo = eo; it.eoe = eoe; it.mask = mask;
        sbq.push_back(it);
        #1;
    endtask

    task automatic drive_in(logic [7:0] x);
        in_bus = x;
        #1;
    endtask

    task automatic load_image(bit mid_check);
        for (int i = CW - 1; i >= 0; i--) begin
            @(negedge clk);
            cfg_shift = 1'b1;
            cfg_sdi   = img[i];
            if (mid_check && i == CW / 2)
                expect_state("R2 enables blank during shift", 16'h0, 16'h0, 16'h0);
        end
        @(negedge clk);
        cfg_shift = 1'b0;
        cfg_load  = 1'b1;
        @(negedge clk);
        cfg_load  = 1'b0;
    endtask

    task automatic pulse(int idx);
        gclk[idx] = 1'b1; #3;
        gclk[idx] = 1'b0; #3;
    endtask

    // ---------------- monitor -----------------------------------------------
    initial begin
        forever begin
            item_t it;
            wait (sbq.size() != 0);
            it = sbq.pop_front();
            checks++;
            if (((mc_out & it.mask) !== (it.eo & it.mask)) || (mc_oe !== it.eoe)) begin
                failures++;
                $display("FAIL %s: out=%h exp_out=%h (mask %h) oe=%h exp_oe=%h",
                         it.tag, mc_out, it.eo, it.mask, mc_oe, it.eoe);
            end
        end
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired: got no finish, expected finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- stimulus ----------------------------------------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_state("R1 reset state", 16'h0000, 16'h0000, 16'hFFFF);

        // mc0: dedicated in0, plus shared pool0
        img[0*LIT +: LIT] = tru(0);
        img[80*LIT +: LIT] = tru(1) | cmp(2);
        img[ORB + 0*16 + 0] = 1'b1;
        img[ORB + 0*16 + 1] = 1'b1;
        img[ORB + 0*16 + 2] = 1'b1;
        // mc1: pool0 and pool1
        img[81*LIT +: LIT] = tru(3);
        img[ORB + 1*16 + 1] = 1'b1;
        // mc2: last dedicated term
        img[14*LIT +: LIT] = cmp(4) | tru(5);
        // mc3: all 5 dedicated terms and all 32 pool terms
        for (int k = 0; k < 5; k++) img[(15+k)*LIT +: LIT] = tru(k) | tru(k+1);
        for (int p = 2; p < 32; p++) begin
            logic [5:0] v;
            logic [15:0] ms;
            v = 6'((p * 37) % 64);
            ms = '0;
            for (int i = 0; i < 6; i++) ms = ms | (v[i] ? tru(i) : cmp(i));
            img[(80+p)*LIT +: LIT] = ms;
        end
        for (int p = 0; p < 32; p++) img[ORB + p*16 + 3] = 1'b1;
        // registered macrocells
        img[25*LIT +: LIT] = tru(0);
        img[30*LIT +: LIT] = tru(0);
        img[35*LIT +: LIT] = tru(1);
        img[40*LIT +: LIT] = tru(2);
        img[45*LIT +: LIT] = tru(2);
        // control terms: ct0 AND in6, ct1 OR in7, ct2 empty, ct3 OR in0/in1
        img[CTB + 0*CTW +: CTW] = {1'b0, tru(6)};
        img[CTB + 1*CTW +: CTW] = {1'b1, tru(7)};
        img[CTB + 3*CTW +: CTW] = {1'b1, tru(0) | tru(1)};
        for (int m = 0; m < 5; m++) img[MCB + m*MCW +: MCW] = mcf(2'd0, 1'b0, 1'b1, 2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0);
        img[MCB + 5*MCW +: MCW] = mcf(2'd2, 1'b0, 1'b0, 2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0);
        img[MCB + 6*MCW +: MCW] = mcf(2'd1, 1'b1, 1'b0, 2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0);
        img[MCB + 7*MCW +: MCW] = mcf(2'd0, 1'b0, 1'b0, 2'd1, 2'd0, 1'b1, 2'd0, 1'b1, 2'd1);
        img[MCB + 8*MCW +: MCW] = mcf(2'd0, 1'b0, 1'b1, 2'd2, 2'd3, 1'b0, 2'd0, 1'b0, 2'd0);
        img[MCB + 9*MCW +: MCW] = mcf(2'd0, 1'b0, 1'b1, 2'd3, 2'd3, 1'b0, 2'd0, 1'b0, 2'd0);

        load_image(1'b0);
        expect_state("R2 committed image enables outputs", exp_sum(8'h00), exp_oe(8'h00, 1'b0), COMB_MASK);

        // R3 R4 R5 R6 R8 R9: every pattern of in[5:0]
        for (int v = 0; v < 64; v++) begin
            drive_in(8'(v));
            expect_state("R3/R4/R5/R6/R8/R9 pattern sweep", exp_sum(8'(v)), exp_oe(8'(v), 1'b0), COMB_MASK);
        end

        // R3 explicit: empty macrocell 4 stays 0, R5 shared pool0 lights 0..2
        drive_in(8'h02);
        expect_state("R5 pool0 shared by mc0..mc2, R3 empty mc4 is 0", 16'h000F, exp_oe(8'h02, 1'b0), 16'h001F);

        // R11
        gts = 1'b1;
        drive_in(8'h3F);
        expect_state("R11 gts blanks enables only", exp_sum(8'h3F), 16'h0000, COMB_MASK);
        gts = 1'b0;
        drive_in(8'h00);

        // R2 reload with live enables
        load_image(1'b1);
        expect_state("R2 enables restored after commit", exp_sum(8'h00), exp_oe(8'h00, 1'b0), COMB_MASK);

        // R7 clock select and polarity
        drive_in(8'h00);
        pulse(2); pulse(1); pulse(0);
        expect_state("R7 registers primed to 0", 16'h0000, exp_oe(8'h00, 1'b0), 16'h00E0);
        drive_in(8'h01);
        gclk[1] = 1'b1; #2;
        expect_state("R7 inverted reg ignores rising edge", 16'h0000, exp_oe(8'h01, 1'b0), 16'h0060);
        gclk[1] = 1'b0; #2;
        expect_state("R7 inverted reg captures falling edge, other clock ignored", 16'h0040, exp_oe(8'h01, 1'b0), 16'h0060);
        pulse(2);
        expect_state("R7 selected clock captures", 16'h0060, exp_oe(8'h01, 1'b0), 16'h0060);
        drive_in(8'h00);
        expect_state("R8 register holds while bypass path follows", 16'h0060, exp_oe(8'h00, 1'b0), 16'h0061);

        // R10 asynchronous set and clear on mc7
        drive_in(8'h40);
        expect_state("R10 set from control term", 16'h0080, exp_oe(8'h40, 1'b0), 16'h0080);
        drive_in(8'h00);
        expect_state("R10 set holds after release", 16'h0080, exp_oe(8'h00, 1'b0), 16'h0080);
        drive_in(8'h80);
        expect_state("R10 clear from control term", 16'h0000, exp_oe(8'h80, 1'b0), 16'h0080);
        drive_in(8'hC0);
        expect_state("R10 clear wins over set", 16'h0000, exp_oe(8'hC0, 1'b0), 16'h0080);
        drive_in(8'h40);
        expect_state("R10 set takes over when clear drops", 16'h0080, exp_oe(8'h40, 1'b0), 16'h0080);
        drive_in(8'h00);
        pulse(0);
        expect_state("R7 clock0 captures d=0 on mc7", 16'h0000, exp_oe(8'h00, 1'b0), 16'h0080);
        drive_in(8'h02);
        pulse(0);
        expect_state("R7 clock0 captures d=1 on mc7", 16'h0080, exp_oe(8'h02, 1'b0), 16'h0080);

        wait (sbq.size() == 0);
        #2;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule